// File: doc/BRIEF.md
# Cyclic Ratio Clock Divider

This block produces a pulse train from its input clock in which the spacing between pulses is not fixed. The spacing steps through three ratios, 3, 5 and 7 input cycles by default, and then starts again at the first. Each period ends with an output that is high for one input cycle. After that the divider switches to the next ratio.

The work is done by two parts. The first is a loadable up-counter of `CNT_W` bits that counts toward its all-ones value. The second is a two-bit selector that holds the current ratio. When the counter reaches all ones, the output pulse is raised, the selector moves forward, and the counter is loaded with the full count range minus the next ratio. With the defaults, a 4-bit counter is loaded with 13, 11 or 9. A synchronous, active-high reset puts the divider at the start of a first-ratio period.

Top module: `cyc_ratio_div`

## Requirements
- R1: While `rst` is sampled high at a rising edge, `pulseOut` is low in the cycle that follows that edge.
- R2: Each time `pulseOut` goes high, it stays high for exactly one clock cycle.
- R3: Number the cycle that begins at the last rising edge with `rst` high as cycle 1. The first pulse is high in cycle 3. Each later pulse starts 5, 7, 3, 5, 7, ... cycles after the one before it, and this order repeats forever.
- R4: A reset applied at any point in the sequence drops the current ratio. The next pulse again follows the R3 timing, starting from the 3-cycle period.
- R5: Over any run of whole cycles of the ratio order starting from reset, the number of pulses is three for every 15 input cycles.
- R6: The ratio selector only ever holds one of the three codes 00, 01 and 10, meaning ratios 3, 5 and 7. The unused code 11 falls back to 00. The counter never holds a value below the smallest load value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; everything updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts at the 3-cycle period |
| pulseOut | output | 1 | Divided output, one cycle high at the end of each period |

## Verification
The only internal state is the counter value and the ratio selector. A wrong counter load makes a period at the port too long or too short within the very first period after reset. A selector that steps out of order or gets stuck shows as a wrong interval by the second or third pulse. So every cycle of a long run is compared against an arithmetic list of pulse positions. The check is repeated after a reset placed at every phase of the 15-cycle pattern, so that errors which depend on the position in the pattern at reset time are also caught.

// File: rtl/cyc_div_pkg.sv
package cyc_div_pkg;
  parameter int DIV_CNT_W = 4;

  typedef struct packed {
    logic                 load;
    logic [DIV_CNT_W-1:0] loadValue;
  } divStrobes_t;
endpackage

// File: rtl/cyc_div_dp.sv
module cyc_div_dp
  import cyc_div_pkg::*;
#(
  parameter int MIN_LOAD = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  divStrobes_t strobes,
  output logic        termCount
);
  logic [DIV_CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (strobes.load) cntQ <= strobes.loadValue;
    else              cntQ <= cntQ + 1'b1;
  end

  assign termCount = &cntQ;

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cntQ) >= MIN_LOAD);
endmodule

// File: rtl/cyc_div_ctrl.sv
module cyc_div_ctrl
  import cyc_div_pkg::*;
#(
  parameter int RATIO_0 = 3,
  parameter int RATIO_1 = 5,
  parameter int RATIO_2 = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        termCount,
  output divStrobes_t strobes
);
  localparam int SPAN = 1 << DIV_CNT_W;

  logic [1:0] modeQ;
  logic [1:0] modeNext;

  function automatic logic [DIV_CNT_W-1:0] loadFor(input logic [1:0] m);
    case (m)
      2'd1:    return DIV_CNT_W'(SPAN - RATIO_1);
      2'd2:    return DIV_CNT_W'(SPAN - RATIO_2);
      default: return DIV_CNT_W'(SPAN - RATIO_0);
    endcase
  endfunction

  always_comb begin
    case (modeQ)
      2'd0:    modeNext = 2'd1;
      2'd1:    modeNext = 2'd2;
      default: modeNext = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            modeQ <= 2'd0;
    else if (termCount) modeQ <= modeNext;
  end

  always_comb begin
    strobes.load      = rst | termCount;
    strobes.loadValue = rst ? loadFor(2'd0) : loadFor(modeNext);
  end

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    modeQ != 2'b11);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !termCount |=> $stable(modeQ));

  // R3
  mode_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (termCount && modeQ == 2'd2) |=> modeQ == 2'd0);
endmodule

// File: rtl/cyc_ratio_div.sv
module cyc_ratio_div
  import cyc_div_pkg::*;
#(
  parameter int RATIO_0 = 3,
  parameter int RATIO_1 = 5,
  parameter int RATIO_2 = 7
) (
  input  logic clk,
  input  logic rst,
  output logic pulseOut
);
  localparam int MAX_RATIO = (RATIO_0 > RATIO_1) ?
                             ((RATIO_0 > RATIO_2) ? RATIO_0 : RATIO_2) :
                             ((RATIO_1 > RATIO_2) ? RATIO_1 : RATIO_2);
  localparam int MIN_LOAD = (1 << DIV_CNT_W) - MAX_RATIO;

  divStrobes_t strobes;
  logic        termCount;

  cyc_div_ctrl #(
    .RATIO_0(RATIO_0), .RATIO_1(RATIO_1), .RATIO_2(RATIO_2)
  ) ctrl_i (
    .clk(clk), .rst(rst), .termCount(termCount), .strobes(strobes)
  );

  cyc_div_dp #(.MIN_LOAD(MIN_LOAD)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .termCount(termCount)
  );

  assign pulseOut = termCount;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pulseOut);

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pulseOut |=> !pulseOut);
endmodule

// File: tb/cyc_ratio_div_tb_top.sv
`timescale 1ns/1ps
module cyc_ratio_div_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulseOut;
  int   testsRun = 0;
  int   testsFailed = 0;
  bit   finished = 0;

  always #4 clk = ~clk;

  cyc_ratio_div dut_i (.clk(clk), .rst(rst), .pulseOut(pulseOut));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratioOf(input int idx);
    return 3 + 2 * (idx % 3);
  endfunction

  // Apply reset for n cycles, release at a negedge; on return we sit in cycle 1.
  task automatic doReset(input int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pulseOut == 1'b0, "R1 low during reset", pulseOut, 0);
    end
    rst = 1'b0;
  endtask

  // Compare cycles 1..len against the arithmetic pulse list.
  task automatic sweep(input int len, input string req, output int pulses);
    int nextPulse = 3;
    int idx = 0;
    int highRun = 0;
    pulses = 0;
    for (int k = 1; k <= len; k++) begin
      bit exp = (k == nextPulse);
      check(pulseOut == exp, req, pulseOut, exp);
      if (pulseOut) begin
        highRun++;
        pulses++;
      end else begin
        if (highRun != 0) check(highRun == 1, "R2 pulse width", highRun, 1);
        highRun = 0;
      end
      if (k == nextPulse) begin
        idx++;
        nextPulse += ratioOf(idx);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int p;
    doReset(3);
    // R3 long run from reset, R5 pulse density over 10 full rounds
    sweep(150, "R3 interval sequence", p);
    check(p == 30, "R5 pulses in 150 cycles", p, 30);
    // R4 reset at every phase of the 15-cycle pattern
    for (int off = 0; off < 15; off++) begin
      for (int i = 0; i < off; i++) @(negedge clk);
      doReset(1 + (off % 2));
      sweep(45, "R4 restart after reset", p);
      check(p == 9, "R5 pulses in 45 cycles", p, 9);
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule